// File: doc/BRIEF.md
# Dual-Mode Serial Write Receiver

This block is a receive-only serial slave that takes bytes from an external controller over a shared clock/data pin pair. A static strap input chooses the protocol. With the strap low the pins act as a framed shift link. An active-low select line opens a frame, and the data line is sampled on each rising clock edge. With the strap high the pins form a two-wire bus slave. That slave recognises START and STOP, compares the first byte after START with a fixed write address, and pulls the data line low to acknowledge the address and every data byte after it.

Every completed byte appears for one system clock on a valid/data output. A frame-start flag marks the first byte of each frame. Bus addresses, command meaning and read transfers are left to the logic downstream. Both pins are brought into the system clock domain through two-flop synchronizers, and all protocol events are decoded from the synchronized copies.

Top module: `dual_serial_rx`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `byte_valid`, `frame_start` and `sda_oe` are 0.
- R2: Shift mode (`mode_i2c`=0): while `sel_n` is low, `sda` is sampled on each `sck` rising edge, most significant bit first. After every 8 samples, `byte_valid` pulses for exactly one cycle with the byte on `byte_data`.
- R3: Shift mode: `frame_start` is 1 together with the first byte after each falling edge of `sel_n`, and 0 for every other byte.
- R4: Shift mode: if `sel_n` rises after fewer than 8 samples, the partial bits are dropped, and the next frame starts counting from bit 7 again.
- R5: Shift mode: clock edges on `sck` while `sel_n` is high produce no byte.
- R6: Bus mode (`mode_i2c`=1): a START is a falling `sda` while `sck` is high, and a STOP is a rising `sda` while `sck` is high. The address byte 0x7A (7-bit address 0x3D, bit 0 = 0 for write) is acknowledged by driving `sda_oe`=1 through the ninth clock pulse.
- R7: Bus mode: after a matched address, each data byte is delivered on `byte_valid`/`byte_data` and acknowledged. The address byte itself is never delivered.
- R8: Bus mode: `frame_start` is 1 on the first data byte after each acknowledged address, including one that follows a repeated START, and 0 on later bytes.
- R9: Bus mode: any address byte other than 0x7A gets no acknowledge, and following bytes are neither delivered nor acknowledged until the next START.
- R10: Bus mode: the address byte 0x7B (matching address, bit 0 = 1 for read) is not acknowledged and is treated like R9.
- R11: `sda_oe` changes only while the synchronized `sck` is low.
- R12: In shift mode `sda_oe` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i2c | input | 1 | Static protocol strap: 1 = two-wire bus slave, 0 = framed shift link |
| sel_n | input | 1 | Active-low frame select (shift mode only) |
| sck | input | 1 | Serial clock pin |
| sda | input | 1 | Serial data pin, as seen on the wire |
| sda_oe | output | 1 | Open-drain pull-down enable for the data pin (acknowledge) |
| byte_valid | output | 1 | One-cycle strobe for a received byte |
| byte_data | output | 8 | Received byte, valid with `byte_valid` |
| frame_start | output | 1 | Marks the first byte of a frame, valid with `byte_valid` |

## Verification
The hardest case to reach is the two-wire acknowledge handoff. The slave's own pull-down shares the wire with the master, so it must hold through the whole ninth clock pulse and let go before the master drives the next bit, without creating a false START or STOP. The bench models the wired-AND line and samples it in the middle of each ninth high phase. It sweeps all 256 possible address bytes, each followed by a data byte, so both the acknowledge and its absence are seen for every value. Shift mode is swept with all 256 byte values in one frame, and then cut short in the middle of a byte.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W) + 1;

    typedef enum logic [2:0] {
        BUS_IDLE,
        BUS_ADDR,
        BUS_ACK,
        BUS_DATA,
        BUS_SKIP
    } bus_state_e;

    typedef struct packed {
        logic              valid;
        logic              first;
        logic [BYTE_W-1:0] data;
    } rx_byte_t;

    typedef struct packed {
        logic clk_rise;
        logic clk_fall;
        logic start;
        logic stop;
    } line_evt_t;

    function automatic logic is_write_to(input logic [BYTE_W-1:0] b,
                                         input logic [BYTE_W-2:0] addr);
        return (b[BYTE_W-1:1] == addr) && !b[0];
    endfunction

    function automatic logic [BYTE_W-1:0] shift_in(input logic [BYTE_W-1:0] sh,
                                                   input logic bit_in);
        return {sh[BYTE_W-2:0], bit_in};
    endfunction
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
    parameter int   WIDTH  = 1,
    parameter int   STAGES = 2,
    parameter logic INIT   = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= {WIDTH{INIT}};
                else if (s == 0) chain[s] <= d;
                else chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/srx_line_events.sv
module srx_line_events
    import serial_rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      scl_s,
    input  logic      sda_s,
    output line_evt_t evt
);
    logic scl_d, sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    always_comb begin
        evt.clk_rise = scl_s && !scl_d;
        evt.clk_fall = !scl_s && scl_d;
        evt.start    = scl_s && scl_d && sda_d && !sda_s;
        evt.stop     = scl_s && scl_d && !sda_d && sda_s;
    end
endmodule

// File: rtl/srx_shift_rx.sv
module srx_shift_rx
    import serial_rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  logic      sel_s,
    input  line_evt_t evt,
    input  logic      sda_s,
    output rx_byte_t  rx
);
    logic [BYTE_W-1:0] sh;
    logic [CNT_W-1:0]  cnt;
    logic              first_pend;

    always_ff @(posedge clk) begin
        if (rst || !en || sel_s) begin
            sh         <= '0;
            cnt        <= '0;
            first_pend <= 1'b1;
            rx.valid   <= 1'b0;
            rx.first   <= 1'b0;
            if (rst) rx.data <= '0;
        end else begin
            rx.valid <= 1'b0;
            if (evt.clk_rise) begin
                sh <= shift_in(sh, sda_s);
                if (cnt == CNT_W'(BYTE_W - 1)) begin
                    cnt        <= '0;
                    rx.valid   <= 1'b1;
                    rx.first   <= first_pend;
                    rx.data    <= shift_in(sh, sda_s);
                    first_pend <= 1'b0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/srx_bus_rx.sv
module srx_bus_rx
    import serial_rx_pkg::*;
#(
    parameter logic [BYTE_W-2:0] DEV_ADDR = 7'h3D
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  line_evt_t evt,
    input  logic      sda_s,
    output rx_byte_t  rx,
    output logic      pull_low
);
    bus_state_e        state;
    logic [BYTE_W-1:0] sh;
    logic [CNT_W-1:0]  cnt;
    logic              first_pend;
    logic              byte_full;

    assign byte_full = (cnt == CNT_W'(BYTE_W));

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state      <= BUS_IDLE;
            sh         <= '0;
            cnt        <= '0;
            first_pend <= 1'b0;
            pull_low   <= 1'b0;
            rx.valid   <= 1'b0;
            rx.first   <= 1'b0;
            if (rst) rx.data <= '0;
        end else begin
            rx.valid <= 1'b0;
            if (evt.start) begin
                state    <= BUS_ADDR;
                cnt      <= '0;
                pull_low <= 1'b0;
            end else if (evt.stop) begin
                state    <= BUS_IDLE;
                cnt      <= '0;
                pull_low <= 1'b0;
            end else begin
                unique case (state)
                    BUS_ADDR: begin
                        if (evt.clk_rise && !byte_full) begin
                            sh  <= shift_in(sh, sda_s);
                            cnt <= cnt + 1'b1;
                        end else if (evt.clk_fall && byte_full) begin
                            cnt <= '0;
                            if (is_write_to(sh, DEV_ADDR)) begin
                                pull_low   <= 1'b1;
                                first_pend <= 1'b1;
                                state      <= BUS_ACK;
                            end else begin
                                state <= BUS_SKIP;
                            end
                        end
                    end
                    BUS_DATA: begin
                        if (evt.clk_rise && !byte_full) begin
                            sh  <= shift_in(sh, sda_s);
                            cnt <= cnt + 1'b1;
                            if (cnt == CNT_W'(BYTE_W - 1)) begin
                                rx.valid   <= 1'b1;
                                rx.first   <= first_pend;
                                rx.data    <= shift_in(sh, sda_s);
                                first_pend <= 1'b0;
                            end
                        end else if (evt.clk_fall && byte_full) begin
                            cnt      <= '0;
                            pull_low <= 1'b1;
                            state    <= BUS_ACK;
                        end
                    end
                    BUS_ACK: begin
                        if (evt.clk_fall) begin
                            pull_low <= 1'b0;
                            state    <= BUS_DATA;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/dual_serial_rx.sv
module dual_serial_rx
    import serial_rx_pkg::*;
#(
    parameter logic [BYTE_W-2:0] DEV_ADDR    = 7'h3D,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_i2c,
    input  logic              sel_n,
    input  logic              sck,
    input  logic              sda,
    output logic              sda_oe,
    output logic              byte_valid,
    output logic [BYTE_W-1:0] byte_data,
    output logic              frame_start
);
    logic [2:0] pins_s;
    logic       scl_s, sda_s, sel_s;
    line_evt_t  evt;
    rx_byte_t   shift_rx, bus_rx;
    logic       bus_pull;

    srx_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .INIT(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({sel_n, sda, sck}),
        .q   (pins_s)
    );

    assign scl_s = pins_s[0];
    assign sda_s = pins_s[1];
    assign sel_s = pins_s[2];

    srx_line_events u_evt (
        .clk   (clk),
        .rst   (rst),
        .scl_s (scl_s),
        .sda_s (sda_s),
        .evt   (evt)
    );

    srx_shift_rx u_shift (
        .clk   (clk),
        .rst   (rst),
        .en    (!mode_i2c),
        .sel_s (sel_s),
        .evt   (evt),
        .sda_s (sda_s),
        .rx    (shift_rx)
    );

    srx_bus_rx #(.DEV_ADDR(DEV_ADDR)) u_bus (
        .clk      (clk),
        .rst      (rst),
        .en       (mode_i2c),
        .evt      (evt),
        .sda_s    (sda_s),
        .rx       (bus_rx),
        .pull_low (bus_pull)
    );

    always_comb begin
        if (mode_i2c) begin
            byte_valid  = bus_rx.valid;
            frame_start = bus_rx.valid && bus_rx.first;
            byte_data   = bus_rx.data;
            sda_oe      = bus_pull;
        end else begin
            byte_valid  = shift_rx.valid;
            frame_start = shift_rx.valid && shift_rx.first;
            byte_data   = shift_rx.data;
            sda_oe      = 1'b0;
        end
    end
endmodule

// File: rtl/dual_serial_rx_checker.sv
module dual_serial_rx_checker (
    input logic clk,
    input logic rst,
    input logic mode_i2c,
    input logic byte_valid,
    input logic frame_start,
    input logic sda_oe,
    input logic scl_s
);
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!byte_valid && !frame_start && !sda_oe));

    a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
        byte_valid |=> !byte_valid);

    a_r3_flag_with_byte: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> byte_valid);

    a_r11_oe_on_low_clock: assert property (@(posedge clk) disable iff (rst)
        (sda_oe != $past(sda_oe)) |-> !$past(scl_s));

    a_r12_shift_no_drive: assert property (@(posedge clk) disable iff (rst)
        !mode_i2c |-> !sda_oe);
endmodule

bind dual_serial_rx dual_serial_rx_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .mode_i2c    (mode_i2c),
    .byte_valid  (byte_valid),
    .frame_start (frame_start),
    .sda_oe      (sda_oe),
    .scl_s       (scl_s)
);

// File: tb/test_dual_serial_rx.sv
module test_dual_serial_rx;
    localparam int Q = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_i2c = 1'b0;
    logic       sel_n = 1'b1;
    logic       sck = 1'b0;
    logic       m_sda = 1'b1;
    logic       sda_line;
    logic       sda_oe, byte_valid, frame_start;
    logic [7:0] byte_data;

    int n_chk = 0;
    int n_err = 0;
    int rx_n = 0;
    int oe_in_shift = 0;
    logic [7:0] rx_d [1024];
    logic       rx_f [1024];

    always #4 clk = ~clk;

    assign sda_line = sda_oe ? 1'b0 : m_sda;

    dual_serial_rx i_dual_serial_rx (
        .clk(clk), .rst(rst), .mode_i2c(mode_i2c), .sel_n(sel_n),
        .sck(sck), .sda(sda_line), .sda_oe(sda_oe), .byte_valid(byte_valid),
        .byte_data(byte_data), .frame_start(frame_start)
    );

    always @(negedge clk) begin
        if (!rst && byte_valid && rx_n < 1024) begin
            rx_d[rx_n] = byte_data;
            rx_f[rx_n] = frame_start;
            rx_n = rx_n + 1;
        end
        if (!rst && !mode_i2c && sda_oe) oe_in_shift = oe_in_shift + 1;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bit(input logic b);
        m_sda = b; wq(Q); sck = 1'b1; wq(Q); sck = 1'b0;
    endtask

    task automatic shift_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) shift_bit(b[i]);
    endtask

    task automatic bus_start;
        m_sda = 1'b1; wq(Q); sck = 1'b1; wq(Q); m_sda = 1'b0; wq(Q); sck = 1'b0; wq(Q);
    endtask

    task automatic bus_stop;
        m_sda = 1'b0; wq(Q); sck = 1'b1; wq(Q); m_sda = 1'b1; wq(Q);
    endtask

    task automatic bus_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wq(Q); sck = 1'b1; wq(Q); sck = 1'b0;
        end
        m_sda = 1'b1; wq(Q); sck = 1'b1; wq(Q/2);
        ack = !sda_line;
        wq(Q - Q/2); sck = 1'b0;
    endtask

    initial begin
        int base;
        logic ack;
        logic exp_ack;
        wq(5);
        chk("R1 byte_valid", int'(byte_valid), 0);
        chk("R1 sda_oe", int'(sda_oe), 0);
        chk("R1 frame_start", int'(frame_start), 0);
        rst = 1'b0; wq(5);

        // R2/R3 shift mode: all byte values in one frame
        base = rx_n;
        sel_n = 1'b0; wq(Q);
        for (int v = 0; v < 256; v++) shift_byte(8'(v));
        wq(8); sel_n = 1'b1; wq(Q);
        chk("R2 byte count", rx_n - base, 256);
        for (int v = 0; v < 256; v++) begin
            chk("R2 byte value", int'(rx_d[base+v]), v);
            chk("R3 frame flag", int'(rx_f[base+v]), (v == 0) ? 1 : 0);
        end

        // R5 clocks while deselected
        base = rx_n;
        shift_byte(8'hC3); shift_byte(8'h3C); wq(8);
        chk("R5 no byte while deselected", rx_n - base, 0);

        // R4 partial byte dropped
        base = rx_n;
        sel_n = 1'b0; wq(Q);
        shift_bit(1'b1); shift_bit(1'b0); shift_bit(1'b1);
        wq(Q); sel_n = 1'b1; wq(3*Q); sel_n = 1'b0; wq(Q);
        shift_byte(8'hA5); shift_byte(8'h5A); wq(8);
        sel_n = 1'b1; wq(Q);
        chk("R4 byte count", rx_n - base, 2);
        chk("R4 realigned byte", int'(rx_d[base]), 8'hA5);
        chk("R4 second byte", int'(rx_d[base+1]), 8'h5A);
        chk("R3 flag after reselect", int'(rx_f[base]), 1);
        chk("R3 flag on later byte", int'(rx_f[base+1]), 0);
        chk("R12 no drive in shift mode", oe_in_shift, 0);

        // bus mode
        mode_i2c = 1'b1; sck = 1'b1; m_sda = 1'b1; wq(10);

        // R6/R9/R10 sweep of every address byte
        for (int a = 0; a < 256; a++) begin
            base = rx_n;
            exp_ack = (a == 8'h7A);
            bus_start;
            bus_byte(8'(a), ack);
            chk(a == 8'h7B ? "R10 address ack" : (exp_ack ? "R6 address ack" : "R9 address ack"),
                int'(ack), int'(exp_ack));
            bus_byte(8'(a ^ 8'h96), ack);
            chk(exp_ack ? "R7 data ack" : "R9 data ack", int'(ack), int'(exp_ack));
            bus_stop;
            wq(4);
            chk(exp_ack ? "R7 delivered" : "R9 not delivered", rx_n - base, exp_ack ? 1 : 0);
            if (exp_ack) chk("R7 data value", int'(rx_d[base]), a ^ 8'h96);
        end

        // R7/R8 multi-byte write
        base = rx_n;
        bus_start;
        bus_byte(8'h7A, ack);
        for (int k = 0; k < 24; k++) begin
            bus_byte(8'((k * 37 + 5) & 8'hFF), ack);
            chk("R7 data ack", int'(ack), 1);
        end
        bus_stop; wq(4);
        chk("R7 count", rx_n - base, 24);
        for (int k = 0; k < 24; k++) begin
            chk("R7 value", int'(rx_d[base+k]), (k * 37 + 5) & 8'hFF);
            chk("R8 flag", int'(rx_f[base+k]), (k == 0) ? 1 : 0);
        end

        // R8 repeated START, and START after an ignored address
        base = rx_n;
        bus_start;
        bus_byte(8'h7A, ack); bus_byte(8'h11, ack); bus_byte(8'h12, ack);
        bus_start;
        bus_byte(8'h7A, ack);
        chk("R6 ack after repeated start", int'(ack), 1);
        bus_byte(8'h22, ack);
        bus_start;
        bus_byte(8'h40, ack);
        chk("R9 no ack", int'(ack), 0);
        bus_byte(8'h33, ack);
        bus_start;
        bus_byte(8'h7A, ack); bus_byte(8'h44, ack);
        bus_stop; wq(4);
        chk("R8 count", rx_n - base, 4);
        chk("R8 v0", int'(rx_d[base]), 8'h11);
        chk("R8 f0", int'(rx_f[base]), 1);
        chk("R8 f1", int'(rx_f[base+1]), 0);
        chk("R8 v2", int'(rx_d[base+2]), 8'h22);
        chk("R8 f2", int'(rx_f[base+2]), 1);
        chk("R9 v3 after new start", int'(rx_d[base+3]), 8'h44);
        chk("R8 f3", int'(rx_f[base+3]), 1);
        chk("R6 released after stop", int'(sda_oe), 0);

        summary;
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=running expected=done");
        summary;
        $finish;
    end
endmodule